// File: doc/BRIEF.md
# Host Bus Special Cycle Handler

This block sits on the processor side of a host bridge and takes in special-cycle transactions. Each transaction carries an 8-bit byte-enable code, and the block decodes that code to find the cycle type. Two types are acknowledgements that the block finishes on its own:

- the flush acknowledge, which an agent sends once its cache sync and flush is done;
- the system management entry acknowledge.

The block completes both on the host side one cycle after it accepts them. Each one also produces a one-cycle pulse that neighbouring logic can watch.

The stop-grant acknowledge goes a different way. The block claims it and raises a request on a PCI-side port so that a special cycle is sent downstream. The host cycle stays open until the PCI side reports that the forwarded cycle ended in a master abort. Only then does the block signal completion to the host.

Codes that match no known type are still completed so that the host bus cannot hang. They also set a sticky status flag. The block handles one special cycle at a time. It never forwards a special cycle to the graphics port.

Top module: `spcyc_handler`

## Requirements
- R1: After a synchronous active-low reset, `host_ready`, `pci_req`, `flush_ack_pulse`, `smm_ack_pulse`, `rsvd_seen` and `gfx_fwd_valid` are all 0, and `pci_msg` is 0.
- R2: A request accepted with code 8'h05 (flush acknowledge) raises `host_ready` and `flush_ack_pulse` for exactly one cycle, in the cycle after acceptance. `pci_req` stays 0.
- R3: A request accepted with code 8'h07 (management-mode acknowledge) raises `host_ready` and `smm_ack_pulse` for exactly one cycle, in the cycle after acceptance. `pci_req` stays 0.
- R4: A request accepted with code 8'h06 (stop-grant acknowledge) raises `pci_req` in the cycle after acceptance, with `pci_msg` equal to the STOPGNT_MSG parameter (default 16'h0012). `host_ready` stays 0 while `pci_req` is high.
- R5: A cycle in which `pci_term` and `pci_mabort` are both 1 while `pci_req` is high is followed by one cycle with `host_ready` = 1 and `pci_req` = 0.
- R6: A termination with `pci_mabort` = 0 leaves `pci_req` high and `host_ready` low.
- R7: Any other code is completed with `host_ready` in the cycle after acceptance, with no pulse and no PCI request. From that same cycle `rsvd_seen` reads 1 and stays 1 until reset.
- R8: Only one cycle is in progress at a time. A request held valid through a completion is accepted again no earlier than the cycle after `host_ready`, so two `host_ready` pulses are never adjacent.
- R9: `gfx_fwd_valid` is 0 for every cycle type.
- R10: A reset while a stop grant waits for termination drops `pci_req` and returns the block to idle.
- R11: A termination that arrives while no PCI request is pending has no effect: `host_ready` and `pci_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Special cycle presented by the host; held until `host_ready` |
| host_code | input | 8 | Byte-enable code of the special cycle |
| host_ready | output | 1 | One-cycle completion of the host cycle |
| pci_req | output | 1 | Stop-grant special cycle requested on the PCI side |
| pci_msg | output | 16 | Message code of the forwarded cycle (0 when idle) |
| pci_term | input | 1 | PCI side reports termination of the forwarded cycle |
| pci_mabort | input | 1 | Qualifies `pci_term` as a master abort |
| flush_ack_pulse | output | 1 | One-cycle pulse on a retired flush acknowledge |
| smm_ack_pulse | output | 1 | One-cycle pulse on a retired management-mode acknowledge |
| rsvd_seen | output | 1 | Sticky flag: a reserved code was accepted |
| gfx_fwd_valid | output | 1 | Graphics-port forward strobe, always idle |

## Verification
Two events can fall in the same cycle. The first is the completion of a retired cycle, which sends `host_ready` high. The second is the host still holding `host_valid` with a new code. The bench provokes this by leaving `host_valid` high across a flush-acknowledge completion and switching the code to the management-mode value. It then checks that the new request is taken only after the ready cycle: the next `host_ready` and `smm_ack_pulse` must appear two cycles later, never adjacent to the first. A second overlap is a PCI termination arriving while the block is idle. The bench checks that this changes neither `host_ready` nor `pci_req`.

// File: rtl/spcyc_pkg.sv
// Package: shared types for the special cycle handler.
// Assumes: a single special cycle in progress at any time.
package spcyc_pkg;

    // Decoded class of a host special cycle.
    typedef enum logic [1:0] {
        KIND_FLUSH   = 2'd0,
        KIND_STOPGNT = 2'd1,
        KIND_SMM     = 2'd2,
        KIND_RSVD    = 2'd3
    } cyc_kind_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FWD    = 2'd1,
        ST_RETIRE = 2'd2
    } ctrl_st_e;

endpackage

// File: rtl/spcyc_decode.sv
// Module: spcyc_decode
// Maps a byte-enable code to a cycle class by exact match. Any code that
// matches none of the three known values is classed as reserved.
// Assumes: the three code parameters are distinct.
module spcyc_decode
    import spcyc_pkg::*;
#(
    parameter int                CODE_W       = 8,
    parameter logic [CODE_W-1:0] FLUSH_CODE   = 8'h05,
    parameter logic [CODE_W-1:0] STOPGNT_CODE = 8'h06,
    parameter logic [CODE_W-1:0] SMM_CODE     = 8'h07
) (
    input  logic [CODE_W-1:0] code,
    output cyc_kind_e         kind
);

    // Purpose: classify the code.
    always_comb begin
        if (code == FLUSH_CODE)
            kind = KIND_FLUSH;
        else if (code == STOPGNT_CODE)
            kind = KIND_STOPGNT;
        else if (code == SMM_CODE)
            kind = KIND_SMM;
        else
            kind = KIND_RSVD;
    end

endmodule

// File: rtl/spcyc_ctrl.sv
// Module: spcyc_ctrl
// Sequencer. It accepts one special cycle while idle and latches its class.
// A stop grant waits in the forwarding state until the PCI port reports a
// master-abort end; every other class goes straight to retire. The retire
// state lasts one cycle and accepts nothing, so the host has time to drop
// or change its request.
// Assumes: the host holds host_valid until it sees the retire cycle.
module spcyc_ctrl
    import spcyc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      host_valid,
    input  cyc_kind_e kind_in,
    input  logic      fwd_done,
    output logic      accept,
    output logic      fwd_start,
    output logic      retire,
    output cyc_kind_e kind_q
);

    ctrl_st_e st;

    // Purpose: a request is taken only from the idle state.
    always_comb begin
        accept    = (st == ST_IDLE) && host_valid;
        fwd_start = accept && (kind_in == KIND_STOPGNT);
        retire    = (st == ST_RETIRE);
    end

    // Purpose: advance the state and latch the class of the accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            kind_q <= KIND_RSVD;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (host_valid) begin
                        kind_q <= kind_in;
                        st     <= (kind_in == KIND_STOPGNT) ? ST_FWD : ST_RETIRE;
                    end
                end
                ST_FWD: begin
                    if (fwd_done)
                        st <= ST_RETIRE;
                end
                ST_RETIRE: st <= ST_IDLE;
                default:   st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spcyc_pci_port.sv
// Module: spcyc_pci_port
// Holds the PCI-side request for a forwarded stop grant. The request stays
// up until a termination qualified as a master abort. A termination without
// that qualifier, or one that comes while no request is up, is ignored.
// Assumes: the PCI side reports at most one termination per request.
module spcyc_pci_port #(
    parameter int               MSG_W       = 16,
    parameter logic [MSG_W-1:0] STOPGNT_MSG = 16'h0012
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic             mabort,
    output logic             req,
    output logic [MSG_W-1:0] msg,
    output logic             done
);

    // Purpose: a master-abort end of a pending request finishes it.
    always_comb begin
        done = req && term && mabort;
        msg  = req ? STOPGNT_MSG : '0;
    end

    // Purpose: set the request on start and clear it on a master-abort end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else if (start)
            req <= 1'b1;
        else if (done)
            req <= 1'b0;
    end

endmodule

// File: rtl/spcyc_handler.sv
// Module: spcyc_handler (top)
// Special cycle handler. It decodes the byte-enable code and retires flush,
// management-mode and reserved cycles locally. A stop grant is forwarded to
// the PCI port and retired only after a master-abort end of that request.
// Reserved codes set a sticky flag. Nothing is ever sent to the graphics port.
// Assumes: synchronous active-low reset; host holds code while valid.
module spcyc_handler
    import spcyc_pkg::*;
#(
    parameter int                CODE_W       = 8,
    parameter int                MSG_W        = 16,
    parameter logic [CODE_W-1:0] FLUSH_CODE   = 8'h05,
    parameter logic [CODE_W-1:0] STOPGNT_CODE = 8'h06,
    parameter logic [CODE_W-1:0] SMM_CODE     = 8'h07,
    parameter logic [MSG_W-1:0]  STOPGNT_MSG  = 16'h0012
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [CODE_W-1:0] host_code,
    output logic              host_ready,
    output logic              pci_req,
    output logic [MSG_W-1:0]  pci_msg,
    input  logic              pci_term,
    input  logic              pci_mabort,
    output logic              flush_ack_pulse,
    output logic              smm_ack_pulse,
    output logic              rsvd_seen,
    output logic              gfx_fwd_valid
);

    cyc_kind_e kind_dec;
    cyc_kind_e kind_q;
    logic      accept;
    logic      fwd_start;
    logic      fwd_done;
    logic      retire;

    spcyc_decode #(
        .CODE_W       (CODE_W),
        .FLUSH_CODE   (FLUSH_CODE),
        .STOPGNT_CODE (STOPGNT_CODE),
        .SMM_CODE     (SMM_CODE)
    ) u_decode (
        .code (host_code),
        .kind (kind_dec)
    );

    spcyc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .kind_in    (kind_dec),
        .fwd_done   (fwd_done),
        .accept     (accept),
        .fwd_start  (fwd_start),
        .retire     (retire),
        .kind_q     (kind_q)
    );

    spcyc_pci_port #(
        .MSG_W       (MSG_W),
        .STOPGNT_MSG (STOPGNT_MSG)
    ) u_pci (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fwd_start),
        .term   (pci_term),
        .mabort (pci_mabort),
        .req    (pci_req),
        .msg    (pci_msg),
        .done   (fwd_done)
    );

    // Purpose: host completion and the acknowledge pulses come from the retire cycle.
    always_comb begin
        host_ready      = retire;
        flush_ack_pulse = retire && (kind_q == KIND_FLUSH);
        smm_ack_pulse   = retire && (kind_q == KIND_SMM);
        gfx_fwd_valid   = 1'b0;
    end

    // Purpose: sticky flag, set when a reserved code is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsvd_seen <= 1'b0;
        else if (accept && (kind_dec == KIND_RSVD))
            rsvd_seen <= 1'b1;
    end

endmodule

// File: rtl/spcyc_handler_chk.sv
// Module: spcyc_handler_chk
// Checker bound to spcyc_handler. It watches the port-level relations over time.
module spcyc_handler_chk (
    input logic clk,
    input logic rst_n,
    input logic host_ready,
    input logic pci_req,
    input logic pci_term,
    input logic pci_mabort,
    input logic flush_ack_pulse,
    input logic smm_ack_pulse,
    input logic rsvd_seen
);

    // R2
    flush_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack_pulse |-> (host_ready && !pci_req));

    // R3
    smm_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smm_ack_pulse |-> (host_ready && !pci_req));

    // R4
    no_ready_while_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req |-> !host_ready);

    // R6
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && !(pci_term && pci_mabort)) |=> pci_req);

    // R5
    mabort_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && pci_term && pci_mabort) |=> (host_ready && !pci_req));

    // R7
    rsvd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_seen |=> rsvd_seen);

    // R8
    single_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    // R8
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_ack_pulse, smm_ack_pulse}));

endmodule

bind spcyc_handler spcyc_handler_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_ready      (host_ready),
    .pci_req         (pci_req),
    .pci_term        (pci_term),
    .pci_mabort      (pci_mabort),
    .flush_ack_pulse (flush_ack_pulse),
    .smm_ack_pulse   (smm_ack_pulse),
    .rsvd_seen       (rsvd_seen)
);

// File: tb/spcyc_handler_test.sv
`timescale 1ns/1ps
module spcyc_handler_test;

    localparam logic [15:0] MSG = 16'h0012;
    localparam int NV = 11;
    // Vector: {code, class}; class 0 flush, 1 stop grant, 2 mgmt, 3 reserved
    localparam logic [9:0] VECS [NV] = '{
        {8'h05, 2'd0}, {8'h06, 2'd1}, {8'h07, 2'd2}, {8'h00, 2'd3},
        {8'h05, 2'd0}, {8'h04, 2'd3}, {8'h08, 2'd3}, {8'h85, 2'd3},
        {8'hFF, 2'd3}, {8'h07, 2'd2}, {8'h06, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [7:0]  host_code = 8'h00;
    logic        pci_term = 1'b0;
    logic        pci_mabort = 1'b0;
    logic        host_ready, pci_req, flush_ack_pulse, smm_ack_pulse;
    logic        rsvd_seen, gfx_fwd_valid;
    logic [15:0] pci_msg;

    int checks = 0;
    int failures = 0;
    bit rsvd_expect = 1'b0;

    always #2 clk = ~clk;

    spcyc_handler uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_valid      (host_valid),
        .host_code       (host_code),
        .host_ready      (host_ready),
        .pci_req         (pci_req),
        .pci_msg         (pci_msg),
        .pci_term        (pci_term),
        .pci_mabort      (pci_mabort),
        .flush_ack_pulse (flush_ack_pulse),
        .smm_ack_pulse   (smm_ack_pulse),
        .rsvd_seen       (rsvd_seen),
        .gfx_fwd_valid   (gfx_fwd_valid)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [7:0] code, input logic [1:0] cls);
        @(negedge clk);
        host_valid = 1'b1;
        host_code  = code;
        @(negedge clk);
        if (cls == 2'd1) begin
            chk("R4 pci_req", {15'd0, pci_req}, 16'd1);
            chk("R4 pci_msg", pci_msg, MSG);
            chk("R4 ready low", {15'd0, host_ready}, 16'd0);
            pci_term = 1'b1; pci_mabort = 1'b0;
            @(negedge clk);
            pci_term = 1'b0;
            chk("R6 req kept", {15'd0, pci_req}, 16'd1);
            chk("R6 ready low", {15'd0, host_ready}, 16'd0);
            pci_term = 1'b1; pci_mabort = 1'b1;
            @(negedge clk);
            pci_term = 1'b0; pci_mabort = 1'b0;
            chk("R5 ready", {15'd0, host_ready}, 16'd1);
            chk("R5 req drop", {15'd0, pci_req}, 16'd0);
        end else begin
            if (cls == 2'd3) rsvd_expect = 1'b1;
            chk("R2 R3 R7 ready", {15'd0, host_ready}, 16'd1);
            chk("R2 flush pulse", {15'd0, flush_ack_pulse}, {15'd0, cls == 2'd0});
            chk("R3 smm pulse", {15'd0, smm_ack_pulse}, {15'd0, cls == 2'd2});
            chk("R7 no pci", {15'd0, pci_req}, 16'd0);
        end
        chk("R7 sticky", {15'd0, rsvd_seen}, {15'd0, rsvd_expect});
        chk("R9 gfx idle", {15'd0, gfx_fwd_valid}, 16'd0);
        host_valid = 1'b0;
        @(negedge clk);
        chk("R8 ready one cycle", {15'd0, host_ready}, 16'd0);
        chk("R2 R3 pulses clear", {14'd0, flush_ack_pulse, smm_ack_pulse}, 16'd0);
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {15'd0, host_ready}, 16'd0);
        chk("R1 outputs", {11'd0, pci_req, flush_ack_pulse, smm_ack_pulse, rsvd_seen, gfx_fwd_valid}, 16'd0);
        chk("R1 msg", pci_msg, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            run_vec(VECS[i][9:2], VECS[i][1:0]);

        // R11: termination while idle
        @(negedge clk);
        pci_term = 1'b1; pci_mabort = 1'b1;
        @(negedge clk);
        pci_term = 1'b0; pci_mabort = 1'b0;
        chk("R11 ready", {15'd0, host_ready}, 16'd0);
        chk("R11 req", {15'd0, pci_req}, 16'd0);

        // R8: request held through completion, code changed to mgmt
        host_valid = 1'b1; host_code = 8'h05;
        @(negedge clk);
        chk("R8 first ready", {15'd0, host_ready}, 16'd1);
        chk("R8 first flush", {15'd0, flush_ack_pulse}, 16'd1);
        host_code = 8'h07;
        @(negedge clk);
        chk("R8 gap", {15'd0, host_ready}, 16'd0);
        @(negedge clk);
        chk("R8 second ready", {15'd0, host_ready}, 16'd1);
        chk("R8 second smm", {15'd0, smm_ack_pulse}, 16'd1);
        host_valid = 1'b0;
        @(negedge clk);

        // R10: reset while waiting for termination
        host_valid = 1'b1; host_code = 8'h06;
        @(negedge clk);
        host_valid = 1'b0;
        chk("R10 pending", {15'd0, pci_req}, 16'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 req cleared", {15'd0, pci_req}, 16'd0);
        chk("R1 sticky cleared", {15'd0, rsvd_seen}, 16'd0);
        rst_n = 1'b1;
        rsvd_expect = 1'b0;
        @(negedge clk);
        chk("R10 idle ready", {15'd0, host_ready}, 16'd0);
        run_vec(8'h05, 2'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule